// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block keeps four general-purpose registers that exchange data over one internal bus. A two-bit source code picks which register drives the bus. Each register has its own load request. A load takes effect only when a registered control condition allows it. The control input is captured at one rising edge, and the loads it allows happen at the following edge. If the control input stays high, the transfer repeats on every edge. A swap command exchanges two registers on a single edge. A direct external write port puts initial values into the registers.

Behind the bus sits a small word memory. An address register is loaded from the low bus bits. A memory write stores the bus value at that address. A read copies the addressed word into a data register. A build-time parameter chooses how the bus is driven. Mux mode uses one selector per bit and always drives the bus. Decoder mode turns the source code into one-hot enables. When its enable input is low, no source drives, the bus reads as zero and an idle flag is raised.

Top module: `regbus_xfer_unit`

## Requirements
- R1: With the bus driven, `bus_out` equals the selected register bit for bit. Source code 0 selects register A, 1 selects B, 2 selects C and 3 selects D. Register A appears at `regs_out[7:0]`, B at `[15:8]`, C at `[23:16]` and D at `[31:24]`.
- R2: `ctrl_p` is registered. A register whose `load_en` bit is set loads the bus at the edge after the one that sampled `ctrl_p` high, and not at the sampling edge itself. With the control state low, no register changes except through a swap or an external write.
- R3: While `ctrl_p` stays high, the load repeats on every edge and takes the bus value current at that edge.
- R4: `swap_req` with two different indices exchanges those two registers on one edge. With equal indices, no register changes.
- R5: When a swap and a bus load target the same register on one edge, the swap wins. Other registers named in `load_en` still load.
- R6: In decoder mode with `bus_en` low, `bus_out` is zero and `bus_idle` is 1. Register loads, address loads and memory writes are ignored. At most one source enable is active at any time.
- R7: In mux mode, `bus_idle` is always 0 and `bus_en` has no effect on the bus or on loads.
- R8: With the control state high, `ar_load` loads the address register from bus bits [3:0], and `mem_wr` stores the bus value into the word the address register points to. Both use the address register value from before the edge.
- R9: `mem_rd` copies the addressed word into the data register at the next edge. If a write to the same word falls on that edge, the data register receives the old word.
- R10: `ext_we` writes `ext_data` into the register indexed by `ext_dst` at the edge. A bus load or a swap of that register on the same edge takes precedence.
- R11: A synchronous reset clears all registers, the address register, the data register, the memory and the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_p | input | 1 | Control condition, registered before it allows loads |
| src_sel | input | 2 | Bus source register index |
| bus_en | input | 1 | Bus drive enable (decoder mode only) |
| load_en | input | 4 | Per-register bus load request |
| swap_req | input | 1 | Exchange two registers |
| swap_a | input | 2 | First swap index |
| swap_b | input | 2 | Second swap index |
| ext_we | input | 1 | External register write |
| ext_dst | input | 2 | External write target |
| ext_data | input | 8 | External write value |
| ar_load | input | 1 | Load address register from bus |
| mem_wr | input | 1 | Store bus into memory at address register |
| mem_rd | input | 1 | Copy addressed word into data register |
| regs_out | output | 32 | All four registers, A in the low byte |
| ar_out | output | 4 | Address register |
| dr_out | output | 8 | Data register |
| bus_out | output | 8 | Current bus value |
| bus_idle | output | 1 | No source drives the bus |

## Verification
A swap and a bus load can hit the same register on the same edge. The bench raises the control condition one cycle early. It then asserts a swap of C and B together with a load of C and D from register A. It expects C and B exchanged, D loaded, and C not taking the bus value. A memory write and a memory read to the same word can also fall on one edge. The bench expects the data register to receive the word from before the write, and the new word on the next read.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
    typedef enum logic {
        BUS_MUX = 1'b0,
        BUS_DEC = 1'b1
    } bus_mode_e;

    localparam int DEF_DATA_W   = 8;
    localparam int DEF_NUM_REGS = 4;
    localparam int DEF_DEPTH    = 16;
endpackage

// File: rtl/regbus_source.sv
module regbus_source
    import regbus_pkg::*;
#(
    parameter int        DATA_W   = DEF_DATA_W,
    parameter int        NUM_REGS = DEF_NUM_REGS,
    parameter bus_mode_e MODE     = BUS_DEC,
    localparam int       SEL_W    = $clog2(NUM_REGS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_REGS*DATA_W-1:0]   regs_flat,
    input  logic [SEL_W-1:0]             sel,
    input  logic                         bus_en,
    output logic [DATA_W-1:0]            bus,
    output logic                         idle,
    output logic [NUM_REGS-1:0]          src_en
);

    generate
        if (MODE == BUS_MUX) begin : g_mux
            // one NUM_REGS-to-1 selector per bus bit
            for (genvar b = 0; b < DATA_W; b++) begin : g_bit
                logic [NUM_REGS-1:0] col;
                for (genvar r = 0; r < NUM_REGS; r++) begin : g_col
                    assign col[r] = regs_flat[r*DATA_W + b];
                end
                assign bus[b] = col[sel];
            end
            assign src_en = NUM_REGS'(1) << sel;
            assign idle   = 1'b0;

            // R7
            mux_never_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !bus_en |-> (!idle && $onehot(src_en)));
        end else begin : g_dec
            logic [NUM_REGS-1:0] dec_en;
            logic [DATA_W-1:0]   bus_v;

            always_comb begin
                dec_en = '0;
                if (bus_en) begin
                    dec_en[sel] = 1'b1;
                end
            end

            always_comb begin
                bus_v = '0;
                for (int r = 0; r < NUM_REGS; r++) begin
                    if (dec_en[r]) begin
                        bus_v |= regs_flat[r*DATA_W +: DATA_W];
                    end
                end
            end

            assign bus    = bus_v;
            assign src_en = dec_en;
            assign idle   = ~|dec_en;

            // R6
            single_driver_chk: assert property (@(posedge clk) disable iff (rst)
                $onehot0(src_en));
            // R6
            idle_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
                !bus_en |-> (idle && bus == '0));
        end
    endgenerate

endmodule

// File: rtl/regbus_bank.sv
module regbus_bank
    import regbus_pkg::*;
#(
    parameter int  DATA_W   = DEF_DATA_W,
    parameter int  NUM_REGS = DEF_NUM_REGS,
    localparam int SEL_W    = $clog2(NUM_REGS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DATA_W-1:0]           bus,
    input  logic                        load_fire,
    input  logic [NUM_REGS-1:0]         load_en,
    input  logic                        swap_req,
    input  logic [SEL_W-1:0]            swap_a,
    input  logic [SEL_W-1:0]            swap_b,
    input  logic                        ext_we,
    input  logic [SEL_W-1:0]            ext_dst,
    input  logic [DATA_W-1:0]           ext_data,
    output logic [NUM_REGS*DATA_W-1:0]  regs_flat
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] r;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  swap_ok;

    assign swap_ok = swap_req && (swap_a != swap_b);

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            // lowest priority: external write
            if (ext_we && ext_dst == SEL_W'(i)) begin
                bank_d.r[i] = ext_data;
            end
            // bus load overrides external write
            if (load_fire && load_en[i]) begin
                bank_d.r[i] = bus;
            end
            // swap overrides both
            if (swap_ok && swap_a == SEL_W'(i)) begin
                bank_d.r[i] = bank_q.r[swap_b];
            end
            if (swap_ok && swap_b == SEL_W'(i)) begin
                bank_d.r[i] = bank_q.r[swap_a];
            end
        end
        if (rst) begin
            bank_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign regs_flat = bank_q;

    // R4 R5
    swap_wins_chk: assert property (@(posedge clk) disable iff (rst)
        swap_ok |=> (bank_q.r[$past(swap_a)] == $past(bank_q.r[swap_b]) &&
                     bank_q.r[$past(swap_b)] == $past(bank_q.r[swap_a])));

    // R4
    self_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (swap_req && swap_a == swap_b && !load_fire && !ext_we) |=> $stable(bank_q));

endmodule

// File: rtl/regbus_mem.sv
module regbus_mem
    import regbus_pkg::*;
#(
    parameter int  DATA_W = DEF_DATA_W,
    parameter int  DEPTH  = DEF_DEPTH,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus,
    input  logic              ar_fire,
    input  logic              wr_fire,
    input  logic              rd_req,
    output logic [AW-1:0]     ar,
    output logic [DATA_W-1:0] dr
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] m;
        logic [AW-1:0]                ar;
        logic [DATA_W-1:0]            dr;
    } mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (rd_req) begin
            mem_d.dr = mem_q.m[mem_q.ar];
        end
        if (wr_fire) begin
            mem_d.m[mem_q.ar] = bus;
        end
        if (ar_fire) begin
            mem_d.ar = bus[AW-1:0];
        end
        if (rst) begin
            mem_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign ar = mem_q.ar;
    assign dr = mem_q.dr;

    // R8
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> mem_q.m[$past(mem_q.ar)] == $past(bus));

    // R8
    ar_from_bus_chk: assert property (@(posedge clk) disable iff (rst)
        ar_fire |=> mem_q.ar == $past(bus[AW-1:0]));

    // R9
    read_old_word_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> mem_q.dr == $past(mem_q.m[mem_q.ar]));

endmodule

// File: rtl/regbus_xfer_unit.sv
module regbus_xfer_unit
    import regbus_pkg::*;
#(
    parameter int        DATA_W    = DEF_DATA_W,
    parameter int        NUM_REGS  = DEF_NUM_REGS,
    parameter int        MEM_DEPTH = DEF_DEPTH,
    parameter bus_mode_e BUS_MODE  = BUS_DEC,
    localparam int       SEL_W     = $clog2(NUM_REGS),
    localparam int       AW        = $clog2(MEM_DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ctrl_p,
    input  logic [SEL_W-1:0]            src_sel,
    input  logic                        bus_en,
    input  logic [NUM_REGS-1:0]         load_en,
    input  logic                        swap_req,
    input  logic [SEL_W-1:0]            swap_a,
    input  logic [SEL_W-1:0]            swap_b,
    input  logic                        ext_we,
    input  logic [SEL_W-1:0]            ext_dst,
    input  logic [DATA_W-1:0]           ext_data,
    input  logic                        ar_load,
    input  logic                        mem_wr,
    input  logic                        mem_rd,
    output logic [NUM_REGS*DATA_W-1:0]  regs_out,
    output logic [AW-1:0]               ar_out,
    output logic [DATA_W-1:0]           dr_out,
    output logic [DATA_W-1:0]           bus_out,
    output logic                        bus_idle
);

    typedef struct packed {
        logic p;
    } ctl_t;

    ctl_t                ctl_d, ctl_q;
    logic [DATA_W-1:0]   bus_w;
    logic                idle_w;
    logic [NUM_REGS-1:0] src_en_w;
    logic                xfer_ok;

    always_comb begin
        ctl_d   = ctl_q;
        ctl_d.p = ctrl_p;
        if (rst) begin
            ctl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign xfer_ok = ctl_q.p && !idle_w;

    regbus_source #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .MODE     (BUS_MODE)
    ) src_i (
        .clk       (clk),
        .rst       (rst),
        .regs_flat (regs_out),
        .sel       (src_sel),
        .bus_en    (bus_en),
        .bus       (bus_w),
        .idle      (idle_w),
        .src_en    (src_en_w)
    );

    regbus_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) bank_i (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus_w),
        .load_fire (xfer_ok),
        .load_en   (load_en),
        .swap_req  (swap_req),
        .swap_a    (swap_a),
        .swap_b    (swap_b),
        .ext_we    (ext_we),
        .ext_dst   (ext_dst),
        .ext_data  (ext_data),
        .regs_flat (regs_out)
    );

    regbus_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (MEM_DEPTH)
    ) mem_i (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus_w),
        .ar_fire (xfer_ok && ar_load),
        .wr_fire (xfer_ok && mem_wr),
        .rd_req  (mem_rd),
        .ar      (ar_out),
        .dr      (dr_out)
    );

    assign bus_out  = bus_w;
    assign bus_idle = idle_w;

    // R1
    bus_follows_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_idle && src_en_w[src_sel]) |-> bus_out == regs_out[src_sel*DATA_W +: DATA_W]);

    // R2
    no_load_without_p_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.p && !swap_req && !ext_we) |=> $stable(regs_out));

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (regs_out == '0 && ar_out == '0 && dr_out == '0));

endmodule

// File: tb/regbus_xfer_unit_tb_top.sv
`timescale 1ns/10ps
module regbus_xfer_unit_tb_top;
    import regbus_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_p = 1'b0;
    logic [1:0] src_sel = '0;
    logic       bus_en = 1'b1;
    logic [3:0] load_en = '0;
    logic       swap_req = 1'b0;
    logic [1:0] swap_a = '0;
    logic [1:0] swap_b = '0;
    logic       ext_we = 1'b0;
    logic [1:0] ext_dst = '0;
    logic [7:0] ext_data = '0;
    logic       ar_load = 1'b0;
    logic       mem_wr = 1'b0;
    logic       mem_rd = 1'b0;

    logic [31:0] regs_out, m_regs;
    logic [3:0]  ar_out, m_ar;
    logic [7:0]  dr_out, m_dr, bus_out, m_bus;
    logic        bus_idle, m_idle;

    always #2.5 clk = ~clk;

    regbus_xfer_unit #(.BUS_MODE(BUS_DEC)) dut_i (
        .clk(clk), .rst(rst), .ctrl_p(ctrl_p), .src_sel(src_sel), .bus_en(bus_en),
        .load_en(load_en), .swap_req(swap_req), .swap_a(swap_a), .swap_b(swap_b),
        .ext_we(ext_we), .ext_dst(ext_dst), .ext_data(ext_data), .ar_load(ar_load),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .regs_out(regs_out), .ar_out(ar_out),
        .dr_out(dr_out), .bus_out(bus_out), .bus_idle(bus_idle)
    );

    regbus_xfer_unit #(.BUS_MODE(BUS_MUX)) dut_mux_i (
        .clk(clk), .rst(rst), .ctrl_p(ctrl_p), .src_sel(src_sel), .bus_en(bus_en),
        .load_en(load_en), .swap_req(swap_req), .swap_a(swap_a), .swap_b(swap_b),
        .ext_we(ext_we), .ext_dst(ext_dst), .ext_data(ext_data), .ar_load(ar_load),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .regs_out(m_regs), .ar_out(m_ar),
        .dr_out(m_dr), .bus_out(m_bus), .bus_idle(m_idle)
    );

    // kinds: 0 reg, 1 bus, 2 idle, 3 ar, 4 dr, 5 mux bus, 6 mux idle, 7 mux reg, 8 mux ar
    typedef struct {
        int         kind;
        int         idx;
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    function automatic logic [7:0] observe(int kind, int idx);
        case (kind)
            0:       return regs_out[idx*8 +: 8];
            1:       return bus_out;
            2:       return {7'b0, bus_idle};
            3:       return {4'b0, ar_out};
            4:       return dr_out;
            5:       return m_bus;
            6:       return {7'b0, m_idle};
            7:       return m_regs[idx*8 +: 8];
            default: return {4'b0, m_ar};
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #0.1;
            while (sb_q.size() != 0) begin
                sb_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = observe(it.kind, it.idx);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic push(int kind, int idx, logic [7:0] exp, string req);
        sb_item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        #0.2;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_regs(logic [7:0] a, logic [7:0] b, logic [7:0] c,
                               logic [7:0] d, string req);
        push(0, 0, a, req);
        push(0, 1, b, req);
        push(0, 2, c, req);
        push(0, 3, d, req);
    endtask

    task automatic ext_write(int dst, logic [7:0] val);
        ext_we = 1'b1; ext_dst = 2'(dst); ext_data = val;
        tick();
        ext_we = 1'b0;
    endtask

    task automatic arm_p();
        ctrl_p = 1'b1;
        tick();
        ctrl_p = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        // R11 reset state
        expect_regs(8'h00, 8'h00, 8'h00, 8'h00, "R11");
        push(3, 0, 8'h00, "R11");
        push(4, 0, 8'h00, "R11");

        // R10 external writes
        ext_write(0, 8'h3C);
        ext_write(1, 8'hA5);
        ext_write(2, 8'h5A);
        ext_write(3, 8'hF0);
        expect_regs(8'h3C, 8'hA5, 8'h5A, 8'hF0, "R10");

        // R1 source encoding
        src_sel = 2'd0; push(1, 0, 8'h3C, "R1");
        src_sel = 2'd1; push(1, 0, 8'hA5, "R1");
        src_sel = 2'd2; push(1, 0, 8'h5A, "R1");
        src_sel = 2'd3; push(1, 0, 8'hF0, "R1");
        push(2, 0, 8'h00, "R1");

        // R2 single transfer B -> C, one edge after P is sampled
        src_sel = 2'd1; load_en = 4'b0100; ctrl_p = 1'b1;
        tick();
        ctrl_p = 1'b0;
        push(0, 2, 8'h5A, "R2");
        tick();
        push(0, 2, 8'hA5, "R2");
        tick();
        load_en = '0;
        expect_regs(8'h3C, 8'hA5, 8'hA5, 8'hF0, "R2");

        // R3 repeated transfer A -> D while P stays high
        src_sel = 2'd0; load_en = 4'b1000; ctrl_p = 1'b1;
        tick();
        tick();
        push(0, 3, 8'h3C, "R3");
        ext_we = 1'b1; ext_dst = 2'd0; ext_data = 8'h11;
        tick();
        ext_we = 1'b0; ctrl_p = 1'b0;
        tick();
        load_en = '0;
        push(0, 3, 8'h11, "R3");
        push(0, 0, 8'h11, "R3");

        // R4 swap A <-> B, then self-swap
        swap_req = 1'b1; swap_a = 2'd0; swap_b = 2'd1;
        tick();
        swap_a = 2'd2; swap_b = 2'd2;
        push(0, 0, 8'hA5, "R4");
        push(0, 1, 8'h11, "R4");
        tick();
        swap_req = 1'b0;
        expect_regs(8'hA5, 8'h11, 8'hA5, 8'h11, "R4");

        // R5 swap C<->B collides with bus load of C and D from A
        ext_write(2, 8'h77);
        arm_p();
        src_sel = 2'd0; load_en = 4'b1100;
        swap_req = 1'b1; swap_a = 2'd2; swap_b = 2'd1;
        tick();
        swap_req = 1'b0; load_en = '0;
        expect_regs(8'hA5, 8'h77, 8'h11, 8'hA5, "R5");

        // R6 / R7 idle bus
        bus_en = 1'b0; src_sel = 2'd1;
        push(1, 0, 8'h00, "R6");
        push(2, 0, 8'h01, "R6");
        push(5, 0, 8'h77, "R7");
        push(6, 0, 8'h00, "R7");
        arm_p();
        load_en = 4'b0001; ar_load = 1'b1;
        tick();
        load_en = '0; ar_load = 1'b0;
        push(0, 0, 8'hA5, "R6");
        push(3, 0, 8'h00, "R6");
        push(7, 0, 8'h77, "R7");
        push(8, 0, 8'h07, "R7");
        bus_en = 1'b1;

        // R8 address load from C (0x11 -> 1), write B (0x77)
        arm_p();
        src_sel = 2'd2; ar_load = 1'b1;
        tick();
        ar_load = 1'b0;
        push(3, 0, 8'h01, "R8");
        arm_p();
        src_sel = 2'd1; mem_wr = 1'b1;
        tick();
        mem_wr = 1'b0;
        mem_rd = 1'b1;
        tick();
        mem_rd = 1'b0;
        push(4, 0, 8'h77, "R8");

        // R9 read and write to the same word on one edge
        arm_p();
        src_sel = 2'd3; mem_wr = 1'b1; mem_rd = 1'b1;
        tick();
        mem_wr = 1'b0;
        push(4, 0, 8'h77, "R9");
        tick();
        mem_rd = 1'b0;
        push(4, 0, 8'hA5, "R9");

        // R6 memory write ignored while idle
        bus_en = 1'b0;
        arm_p();
        mem_wr = 1'b1;
        tick();
        mem_wr = 1'b0; bus_en = 1'b1; mem_rd = 1'b1;
        tick();
        mem_rd = 1'b0;
        push(4, 0, 8'hA5, "R6");

        // R11 reset again
        rst = 1'b1;
        tick();
        rst = 1'b0;
        expect_regs(8'h00, 8'h00, 8'h00, 8'h00, "R11");
        push(4, 0, 8'h00, "R11");
        push(3, 0, 8'h00, "R11");

        tick();
        wait (sb_q.size() == 0);
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule